// File: doc/BRIEF.md
# Local Bus Master Controller

This block turns single read and write requests from inside the chip into external local-bus cycles. Each cycle has four steps. The first clock raises the address latch enable. The second clock holds the address. Next comes a command phase, whose length is set by a wait-state count. A final clock returns the acknowledge. The external side has a dedicated 16-bit address output and a 16-bit shared address/data pin group. The shared group is split into separate output, per-bit output-enable and input vectors, so the pad ring can build the tri-state buffers.

Configuration selects 8-bit or 16-bit data width, and multiplexed or de-multiplexed addressing. In the multiplexed modes the address goes out on the shared pins while the latch enable is high. It stays there for one hold clock, so an external latch can capture it on the falling edge of the enable. In 8-bit multiplexed mode only the low half of the shared pins is used for data, and the high half keeps carrying the upper address byte. In the de-multiplexed modes the address stays on the dedicated output and the shared pins carry only data. The requester sees a ready flag, a one-clock acknowledge per access, and the captured read data.

Top module: `lbus_master`

## Requirements
- R1: After reset `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ad_oe`=0, `ack_rd`=0, `ack_wr`=0 and `req_ready`=1.
- R2: A request is taken only at a clock edge where `req_ready`=1 and `req_valid`=1. `req_ready` is 0 from that edge until the acknowledge. A request raised while `req_ready`=0 has no effect: no latch enable appears for it and the running cycle keeps its timing.
- R3: `bus_ale` is 1 for exactly the one clock after acceptance. The next clock is an address-hold clock with `bus_ale`=0 and both strobes high. The address used is `req_addr` with bit 0 forced to 0 in 16-bit modes, and `req_addr` unchanged in 8-bit modes.
- R4: In 16-bit multiplexed mode all 16 shared pins drive the address (`bus_ad_oe`=16'hFFFF) in the latch and hold clocks. In the command phase they drive the write data, or are released (`bus_ad_oe`=0) for a read.
- R5: In 8-bit multiplexed mode the upper 8 shared pins drive address bits 15..8 with output enable set for the whole cycle. The lower 8 pins carry address bits 7..0 first. They then carry write-data bits 7..0, or are released for a read.
- R6: In de-multiplexed modes `bus_addr` holds the address from the latch clock until the next cycle starts, and the shared pins never drive the address. In multiplexed modes `bus_addr` is 0. In 8-bit de-multiplexed mode only the lower 8 shared pins drive data.
- R7: The command strobe is low for exactly 1+W clocks, with W = `cfg_wait` (0 to 15). The strobe is `bus_rd_n` for reads and `bus_wr_n` for writes. The two strobes are never low together.
- R8: Read data is sampled from `bus_ad_in` at the edge that ends the last command clock. It appears on `rd_data` together with `ack_rd`. In 8-bit modes the value is zero-extended from bits 7..0. On `ack_rd` the shared pins are released to `bus_ad_oe`=0.
- R9: After a write ends, the shared pins keep driving the write data (with the upper address byte in 8-bit multiplexed mode) until the next cycle starts.
- R10: `ack_rd` or `ack_wr` is a one-clock pulse in the clock after the last low strobe clock. `req_ready` returns to 1 in that same clock.
- R11: Mode and wait count are sampled at acceptance. Changing `cfg_wait` during a cycle does not change that cycle's strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_mux | input | 1 | 1 = multiplexed address/data, 0 = separate address |
| cfg_wait | input | 4 | Extra command-phase clocks |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | 16 | Captured read data |
| ack_rd | output | 1 | Read complete pulse |
| ack_wr | output | 1 | Write complete pulse |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | 16 | Dedicated address output |
| bus_ad_out | output | 16 | Shared pin output values |
| bus_ad_oe | output | 16 | Shared pin output enables, per bit |
| bus_ad_in | input | 16 | Shared pin input values |

## Verification
Counting from the edge that accepts a request, the latch enable is due one clock later and the hold clock two clocks later. The strobe is low from the third clock through clock 3+W, and the acknowledge, read data and ready come at clock 4+W. The driver task samples at each falling edge of the clock, so a check never lands on the active edge. It walks exactly these clock offsets for the wait count it programmed, and it changes the read input during the early command clocks to show that only the last one is sampled. A monitor at the same falling edges pops the expected item from the queue when an acknowledge appears.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ALE  = 2'd1,
    PH_HOLD = 2'd2,
    PH_CMD  = 2'd3
  } lbm_phase_e;

  typedef struct packed {
    logic wide;
    logic mux;
  } lbm_mode_t;
endpackage

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
#(
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [WSW-1:0] wait_cfg,
  output lbm_phase_e     phase,
  output logic           cmd_last
);
  logic [WSW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_ALE;
          cnt   <= wait_cfg;
        end
        PH_ALE:  phase <= PH_HOLD;
        PH_HOLD: phase <= PH_CMD;
        PH_CMD: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cmd_last = (phase == PH_CMD) && (cnt == '0);
endmodule

// File: rtl/lbm_pins.sv
module lbm_pins
  import lbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  lbm_phase_e    phase,
  input  logic          cmd_last,
  input  lbm_mode_t     mode_in,
  input  logic          wr_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rd_data,
  output logic          ack_rd,
  output logic          ack_wr,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] ad_out,
  output logic [DW-1:0] ad_oe
);
  localparam int HALF = DW / 2;

  lbm_mode_t     m_mode;
  logic          m_wr;
  logic [DW-1:0] m_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_mode   <= '0;
      m_wr     <= 1'b0;
      m_wdata  <= '0;
      rd_data  <= '0;
      ack_rd   <= 1'b0;
      ack_wr   <= 1'b0;
      ale      <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      bus_addr <= '0;
      ad_out   <= '0;
      ad_oe    <= '0;
    end else begin
      ack_rd <= 1'b0;
      ack_wr <= 1'b0;
      if (start) begin
        m_mode  <= mode_in;
        m_wr    <= wr_in;
        m_wdata <= wdata_in;
        ale     <= 1'b1;
        if (mode_in.mux) begin
          ad_out   <= DW'(addr_in);
          ad_oe    <= '1;
          bus_addr <= '0;
        end else begin
          bus_addr <= addr_in;
          ad_oe    <= '0;
        end
      end else begin
        unique case (phase)
          PH_ALE: ale <= 1'b0;
          PH_HOLD: begin
            if (m_wr) wr_n <= 1'b0;
            else      rd_n <= 1'b0;
            if (m_mode.wide) begin
              ad_out <= m_wdata;
              ad_oe  <= {DW{m_wr}};
            end else begin
              ad_out[HALF-1:0]  <= m_wdata[HALF-1:0];
              ad_oe[HALF-1:0]   <= {HALF{m_wr}};
              ad_oe[DW-1:HALF]  <= {(DW-HALF){m_mode.mux}};
            end
          end
          PH_CMD: if (cmd_last) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
            if (m_wr) begin
              ack_wr <= 1'b1;
            end else begin
              ack_rd <= 1'b1;
              ad_oe  <= '0;
              rd_data <= m_mode.wide ? ad_in
                                     : {{(DW-HALF){1'b0}}, ad_in[HALF-1:0]};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lbus_master.sv
module lbus_master
  import lbm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wide,
  input  logic           cfg_mux,
  input  logic [WSW-1:0] cfg_wait,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_ready,
  output logic [DW-1:0]  rd_data,
  output logic           ack_rd,
  output logic           ack_wr,
  output logic           bus_ale,
  output logic           bus_rd_n,
  output logic           bus_wr_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_ad_out,
  output logic [DW-1:0]  bus_ad_oe,
  input  logic [DW-1:0]  bus_ad_in
);
  lbm_phase_e    phase;
  logic          cmd_last;
  logic          start;
  lbm_mode_t     mode;
  logic [AW-1:0] addr_eff;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_ready && req_valid;
  assign mode      = '{wide: cfg_wide, mux: cfg_mux};
  assign addr_eff  = cfg_wide ? {req_addr[AW-1:1], 1'b0} : req_addr;

  lbm_seq #(.WSW(WSW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wait_cfg (cfg_wait),
    .phase    (phase),
    .cmd_last (cmd_last)
  );

  lbm_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .phase    (phase),
    .cmd_last (cmd_last),
    .mode_in  (mode),
    .wr_in    (req_write),
    .addr_in  (addr_eff),
    .wdata_in (req_wdata),
    .ad_in    (bus_ad_in),
    .rd_data  (rd_data),
    .ack_rd   (ack_rd),
    .ack_wr   (ack_wr),
    .ale      (bus_ale),
    .rd_n     (bus_rd_n),
    .wr_n     (bus_wr_n),
    .bus_addr (bus_addr),
    .ad_out   (bus_ad_out),
    .ad_oe    (bus_ad_oe)
  );
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus_ale,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic [DW-1:0] bus_ad_out,
  input logic [DW-1:0] bus_ad_oe,
  input logic          ack_rd,
  input logic          ack_wr
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n)); // R7
  AST_ACCEPT_ALE: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> (bus_ale && !req_ready)); // R2
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale); // R3
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(bus_ale, 2)); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    (ack_rd || ack_wr) |=> !(ack_rd || ack_wr)); // R10
  AST_ACK_READY: assert property (@(posedge clk) disable iff (rst)
    (ack_rd || ack_wr) |-> (req_ready && bus_rd_n && bus_wr_n)); // R10
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ack_rd |-> (bus_ad_oe == '0 && !$past(bus_rd_n))); // R8
  AST_WR_KEEP: assert property (@(posedge clk) disable iff (rst)
    ack_wr |-> ($stable(bus_ad_out) && $stable(bus_ad_oe))); // R9
endmodule

bind lbus_master lbm_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .bus_ale    (bus_ale),
  .bus_rd_n   (bus_rd_n),
  .bus_wr_n   (bus_wr_n),
  .bus_ad_out (bus_ad_out),
  .bus_ad_oe  (bus_ad_oe),
  .ack_rd     (ack_rd),
  .ack_wr     (ack_wr)
);

// File: tb/tb_lbus_master.sv
`timescale 1ns/1ps
module tb_lbus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b0, cfg_mux = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, bus_ad_in = '0;
  logic        req_ready, ack_rd, ack_wr, bus_ale, bus_rd_n, bus_wr_n;
  logic [15:0] rd_data, bus_addr, bus_ad_out, bus_ad_oe;

  always #2.5 clk = ~clk;

  lbus_master dut (.*);

  int checks = 0;
  int fails  = 0;

  typedef struct { bit wr; logic [15:0] val; logic [15:0] oe; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Monitor: compares acknowledged results against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && (ack_rd || ack_wr)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected ack", {30'd0, ack_rd, ack_wr}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(ack_wr == e.wr && ack_rd == !e.wr, "R10 ack type", {30'd0, ack_rd, ack_wr}, {30'd0, !e.wr, e.wr});
        if (e.wr)
          chk(((bus_ad_out & e.oe) == (e.val & e.oe)) && bus_ad_oe == e.oe, "R9 write data held",
              {bus_ad_oe, bus_ad_out & e.oe}, {e.oe, e.val & e.oe});
        else
          chk(rd_data == e.val && bus_ad_oe == 16'h0, "R8 read data", {bus_ad_oe, rd_data}, {16'h0, e.val});
      end
    end
  end

  task automatic txn(input bit wide, input bit mux, input int w, input bit wr,
                     input logic [15:0] addr, input logic [15:0] wdata, input logic [15:0] rdpat,
                     input bit poke, input int chg_w);
    logic [15:0] ae, woe, wval, roe;
    exp_t e;
    ae   = wide ? {addr[15:1], 1'b0} : addr;
    woe  = wide ? 16'hFFFF : (mux ? 16'hFFFF : 16'h00FF);
    wval = wide ? wdata : {ae[15:8], wdata[7:0]};
    roe  = (!wide && mux) ? 16'hFF00 : 16'h0000;
    e.wr = wr; e.oe = woe;
    e.val = wr ? wval : (wide ? rdpat : {8'h00, rdpat[7:0]});
    q.push_back(e);
    chk(req_ready == 1'b1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
    cfg_wide = wide; cfg_mux = mux; cfg_wait = 4'(w);
    req_write = wr; req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    bus_ad_in = ~rdpat;
    @(negedge clk); // clock after acceptance: latch enable
    req_valid = 1'b0;
    if (chg_w >= 0) cfg_wait = 4'(chg_w);
    chk(bus_ale == 1'b1 && req_ready == 1'b0, "R3 ale phase", {30'd0, bus_ale, req_ready}, 32'd2);
    if (mux)
      chk(bus_ad_out == ae && bus_ad_oe == 16'hFFFF && bus_addr == 16'h0, wide ? "R4 addr on pins" : "R5 addr on pins",
          {bus_ad_oe, bus_ad_out}, {16'hFFFF, ae});
    else
      chk(bus_addr == ae && bus_ad_oe == 16'h0, "R6 demux address", {bus_ad_oe, bus_addr}, {16'h0, ae});
    @(negedge clk); // hold clock
    chk(bus_ale == 1'b0 && bus_rd_n && bus_wr_n, "R3 hold phase", {29'd0, bus_ale, bus_rd_n, bus_wr_n}, 32'd3);
    if (mux)
      chk(bus_ad_out == ae && bus_ad_oe == 16'hFFFF, wide ? "R4 addr hold" : "R5 addr hold",
          {bus_ad_oe, bus_ad_out}, {16'hFFFF, ae});
    if (poke) begin
      req_valid = 1'b1; req_addr = 16'hFFFF;
    end
    for (int k = 0; k <= w; k++) begin
      if (k == w) bus_ad_in = rdpat;
      @(negedge clk); // command clock k
      if (poke && k == 0) begin
        req_valid = 1'b0;
        chk(bus_ale == 1'b0, "R2 busy request ignored", {31'd0, bus_ale}, 32'd0);
      end
      chk(wr ? (!bus_wr_n && bus_rd_n) : (!bus_rd_n && bus_wr_n), "R7 strobe low",
          {30'd0, bus_rd_n, bus_wr_n}, wr ? 32'd2 : 32'd1);
      if (k == 0) begin
        if (wr)
          chk(((bus_ad_out & woe) == (wval & woe)) && bus_ad_oe == woe,
              wide ? "R4 write data" : (mux ? "R5 write data" : "R6 write data"),
              {bus_ad_oe, bus_ad_out & woe}, {woe, wval & woe});
        else
          chk(bus_ad_oe == roe, "R4 read release", {16'h0, bus_ad_oe}, {16'h0, roe});
        if (!wide && mux)
          chk(bus_ad_out[15:8] == ae[15:8] && bus_ad_oe[15:8] == 8'hFF, "R5 upper address kept",
              {16'h0, bus_ad_oe[15:8], bus_ad_out[15:8]}, {16'h0, 8'hFF, ae[15:8]});
        if (!mux)
          chk(bus_addr == ae, "R6 address held", {16'h0, bus_addr}, {16'h0, ae});
      end
    end
    @(negedge clk); // acknowledge clock
    chk(bus_rd_n && bus_wr_n && req_ready, "R10 done and ready", {29'd0, bus_rd_n, bus_wr_n, req_ready}, 32'd7);
    chk(ack_rd == !wr && ack_wr == wr, chg_w >= 0 ? "R11 length fixed at accept" : "R7 strobe length",
        {30'd0, ack_rd, ack_wr}, {30'd0, !wr, wr});
    @(negedge clk);
    chk(!ack_rd && !ack_wr && !bus_ale, "R10 ack single pulse", {29'd0, ack_rd, ack_wr, bus_ale}, 32'd0);
    if (wr)
      chk(((bus_ad_out & woe) == (wval & woe)) && bus_ad_oe == woe, "R9 data stays driven",
          {bus_ad_oe, bus_ad_out & woe}, {woe, wval & woe});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_ale && bus_rd_n && bus_wr_n && bus_ad_oe == 16'h0 && !ack_rd && !ack_wr && req_ready,
        "R1 reset state", {bus_ad_oe, 10'd0, bus_ale, bus_rd_n, bus_wr_n, ack_rd, ack_wr, req_ready},
        {16'h0, 10'd0, 6'b011001});
    txn(1, 1, 0,  0, 16'h1234, 16'h0000, 16'hBEEF, 0, -1); // wide mux read
    txn(1, 1, 3,  1, 16'h4321, 16'hCAFE, 16'h0000, 0, -1); // wide mux write
    txn(0, 1, 2,  0, 16'hA5C3, 16'h0000, 16'h5A7E, 0, -1); // 8-bit mux read
    txn(0, 1, 1,  1, 16'h9F01, 16'h77AB, 16'h0000, 0, -1); // 8-bit mux write
    txn(1, 0, 15, 0, 16'h0F0F, 16'h0000, 16'h1357, 0, -1); // wide demux read, max waits
    txn(1, 0, 0,  1, 16'h8001, 16'hD00D, 16'h0000, 0, -1); // wide demux write, odd addr
    txn(0, 0, 4,  1, 16'h00FF, 16'h3C96, 16'h0000, 0, -1); // 8-bit demux write
    txn(0, 0, 0,  0, 16'h2222, 16'h0000, 16'hE1F2, 0, -1); // 8-bit demux read
    txn(1, 1, 2,  0, 16'h6666, 16'h0000, 16'h2468, 1, 9);  // busy poke + cfg change
    txn(0, 1, 5,  1, 16'hC0DE, 16'h1155, 16'h0000, 1, 0);  // busy poke + cfg change
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 all acks seen", q.size(), 32'd0);
    finish_run();
  end
endmodule